// File: doc/BRIEF.md
# Eight-Source Two-Level Interrupt Arbiter

This block collects interrupt requests from eight sources of an 8-bit controller core and picks one to hand to the core. Six of the sources arrive as ready-made request flags: two legacy external lines, three timer flags and the serial flag. The remaining two are raw external pins that this block samples itself. Each of those two pins can be set to follow a low level or to latch a falling edge into a pending flag. An enable bit and a priority bit exist per source, and one global enable gates everything.

The winner is chosen by priority level first. Within one level it goes by a fixed source order. The block presents a request strobe and the vector address of the winning source. The core answers with a one-cycle acknowledge, which pushes the serviced level onto a two-entry nesting record and clears a latched edge flag. A return strobe from the core pops the most recent level. Low-priority service can be interrupted by a high-priority source, and high-priority service cannot be interrupted at all.

Top module: `irq8_ctrl`

## Requirements
- R1: Source index k (0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 timer 2, 6 added line A, 7 added line B) presents vector 03h + 8*k on `vec_o` while `irq_o` is high.
- R2: Among requesting sources of equal priority, the lowest index wins.
- R3: A source whose priority bit is 1 wins over every source whose priority bit is 0, whatever their indices. Priority bits for sources 0..5 are bits 0..5 of the priority byte. For line A the priority bit is control bit 3, and for line B it is control bit 7.
- R4: Enable byte bits 0..5 enable sources 0..5 and bit 7 is the global enable. A disabled source, or any source while bit 7 is 0, never raises `irq_o`.
- R5: The control byte holds, from bit 0 upward: line A type, line A pending flag, line A enable, line A priority, and then the same four fields for line B in bits 4..7. `xctl_o` reads the byte back.
- R6: With its type bit at 1, a line latches a falling edge of its pin into its pending flag, and that flag is the line's request. A pin that stays low raises no further request.
- R7: Acknowledging line A or line B clears that line's pending flag. Software may also write the flag.
- R8: With its type bit at 0, a line requests exactly while its pin is low, and its pending flag is not set.
- R9: In the cycle after `ack_i`, `irq_o` is low, so one vector is handed over per acknowledge.
- R10: During low-priority service only high-priority sources may raise `irq_o`. During high-priority service no source may raise it.
- R11: `reti_i` ends the most recently entered service level: high-priority service first, and low-priority service after that.
- R12: After reset every register and flag is 0, `irq_o` is low, and `xctl_o` reads 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_req_i | input | 6 | Request flags of sources 0..5 |
| ext_a_pin_i | input | 1 | Raw pin of added line A (source 6) |
| ext_b_pin_i | input | 1 | Raw pin of added line B (source 7) |
| en_wr_i | input | 1 | Write `wdata_i` to the enable byte |
| pri_wr_i | input | 1 | Write `wdata_i` to the priority byte |
| xctl_wr_i | input | 1 | Write `wdata_i` to the control byte |
| wdata_i | input | 8 | Write data |
| xctl_o | output | 8 | Control byte readback, including the pending flags |
| irq_o | output | 1 | Request to the core |
| vec_o | output | 8 | Vector address of the presented source |
| ack_i | input | 1 | Core takes the presented vector (one-cycle pulse) |
| reti_i | input | 1 | Core returns from the current service level |

## Verification
The assertions assume that `ack_i` is a one-cycle pulse given only while `irq_o` is high. They also assume that `reti_i` never coincides with `ack_i` and is issued only while a level is active. The bench pulses both strobes for a single cycle at a falling clock edge, gives `ack_i` only after it has seen `irq_o` high, and keeps every return matched to an earlier acknowledge. A full sweep over all pairs of sources and all priority combinations runs with no acknowledge at all, so no service level is active during it.

// File: rtl/irq8_pkg.sv
package irq8_pkg;
  localparam int unsigned NSRC = 8;
  localparam int unsigned IDXW = $clog2(NSRC);
  localparam int unsigned VW   = 8;

  // lowest set index wins
  function automatic logic [IDXW-1:0] first_set(input logic [NSRC-1:0] v);
    logic [IDXW-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) r = IDXW'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/irq8_line.sv
module irq8_line #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic edge_mode_i,
  input  logic flag_wr_i,
  input  logic flag_wd_i,
  input  logic flag_clr_i,
  output logic flag_o,
  output logic req_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q, flag_q, pin_s, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign pin_s = sync_q[SYNC_STAGES-1];
  assign fall  = prev_q & ~pin_s;

  // a fresh edge beats a clear so no edge is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                flag_q <= 1'b0;
    else if (edge_mode_i && fall) flag_q <= 1'b1;
    else if (flag_clr_i)        flag_q <= 1'b0;
    else if (flag_wr_i)         flag_q <= flag_wd_i;
  end

  assign flag_o = flag_q;
  assign req_o  = edge_mode_i ? flag_q : ~pin_s;
endmodule

// File: rtl/irq8_pick.sv
module irq8_pick
  import irq8_pkg::*;
(
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] hi_i,
  input  logic            allow_lo_i,
  input  logic            allow_hi_i,
  output logic            valid_o,
  output logic [IDXW-1:0] idx_o
);
  logic [NSRC-1:0] hi_req, lo_req;

  assign hi_req = req_i &  hi_i & {NSRC{allow_hi_i}};
  assign lo_req = req_i & ~hi_i & {NSRC{allow_lo_i}};

  always_comb begin
    valid_o = |hi_req | |lo_req;
    idx_o   = (|hi_req) ? first_set(hi_req) : first_set(lo_req);
  end
endmodule

// File: rtl/irq8_levels.sv
module irq8_levels (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  logic push_hi_i,
  input  logic pop_i,
  output logic act_hi_o,
  output logic act_lo_o
);
  logic hi_q, lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else if (push_i) begin
      if (push_hi_i) hi_q <= 1'b1;
      else           lo_q <= 1'b1;
    end else if (pop_i) begin
      if (hi_q) hi_q <= 1'b0;
      else      lo_q <= 1'b0;
    end
  end

  assign act_hi_o = hi_q;
  assign act_lo_o = lo_q;
endmodule

// File: rtl/irq8_ctrl.sv
module irq8_ctrl
  import irq8_pkg::*;
#(
  parameter logic [7:0]  VEC_BASE    = 8'h03,
  parameter logic [7:0]  VEC_STRIDE  = 8'd8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [5:0] src_req_i,
  input  logic       ext_a_pin_i,
  input  logic       ext_b_pin_i,
  input  logic       en_wr_i,
  input  logic       pri_wr_i,
  input  logic       xctl_wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] xctl_o,
  output logic       irq_o,
  output logic [7:0] vec_o,
  input  logic       ack_i,
  input  logic       reti_i
);
  localparam int unsigned NLEG = 6;
  localparam int unsigned NEXT = NSRC - NLEG;

  logic [NLEG-1:0] en_q, pri_q;
  logic            glb_q;
  logic [NEXT-1:0] typ_q, ex_q, px_q, flag, line_req, flag_clr;
  logic [NSRC-1:0] req_all, en_all, hi_all;
  logic            act_hi, act_lo, valid, irq_q, take;
  logic [IDXW-1:0] idx, src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      glb_q <= 1'b0;
      pri_q <= '0;
      typ_q <= '0;
      ex_q  <= '0;
      px_q  <= '0;
    end else begin
      if (en_wr_i) begin
        en_q  <= wdata_i[NLEG-1:0];
        glb_q <= wdata_i[7];
      end
      if (pri_wr_i) pri_q <= wdata_i[NLEG-1:0];
      if (xctl_wr_i) begin
        typ_q <= {wdata_i[4], wdata_i[0]};
        ex_q  <= {wdata_i[6], wdata_i[2]};
        px_q  <= {wdata_i[7], wdata_i[3]};
      end
    end
  end

  assign take = ack_i & irq_q;

  logic [NEXT-1:0] pins;
  assign pins = {ext_b_pin_i, ext_a_pin_i};

  for (genvar g = 0; g < NEXT; g++) begin : g_line
    assign flag_clr[g] = take && (src_q == IDXW'(NLEG + g));
    irq8_line #(.SYNC_STAGES(SYNC_STAGES)) u_line (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_i      (pins[g]),
      .edge_mode_i(typ_q[g]),
      .flag_wr_i  (xctl_wr_i),
      .flag_wd_i  (wdata_i[4*g+1]),
      .flag_clr_i (flag_clr[g]),
      .flag_o     (flag[g]),
      .req_o      (line_req[g])
    );
  end

  assign req_all = {line_req, src_req_i};
  assign en_all  = {ex_q, en_q} & {NSRC{glb_q}};
  assign hi_all  = {px_q, pri_q};

  irq8_pick u_pick (
    .req_i     (req_all & en_all),
    .hi_i      (hi_all),
    .allow_lo_i(~act_hi & ~act_lo),
    .allow_hi_i(~act_hi),
    .valid_o   (valid),
    .idx_o     (idx)
  );

  irq8_levels u_lvl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (take),
    .push_hi_i(hi_all[src_q]),
    .pop_i    (reti_i),
    .act_hi_o (act_hi),
    .act_lo_o (act_lo)
  );

  // ack drops the strobe for a cycle so a vector is handed over once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      src_q <= '0;
    end else if (ack_i) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= valid;
      if (valid) src_q <= idx;
    end
  end

  assign irq_o  = irq_q;
  assign vec_o  = VEC_BASE + VEC_STRIDE * {{(VW-IDXW){1'b0}}, src_q};
  assign xctl_o = {px_q[1], ex_q[1], flag[1], typ_q[1],
                   px_q[0], ex_q[0], flag[0], typ_q[0]};
endmodule

// File: rtl/irq8_chk.sv
module irq8_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ack_i,
  input logic       reti_i,
  input logic       irq_o,
  input logic [7:0] vec_o,
  input logic       glb_i,
  input logic       act_hi_i
);
  // R9
  ack_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !irq_o);
  // R1
  vec_fmt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (vec_o[2:0] == 3'd3 && vec_o < 8'h40));
  // R10
  hi_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_hi_i |-> !irq_o);
  // R4
  glb_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_i |=> !irq_o);
  // R11
  pop_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !ack_i && act_hi_i) |=> !act_hi_i);
endmodule

bind irq8_ctrl irq8_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ack_i   (ack_i),
  .reti_i  (reti_i),
  .irq_o   (irq_o),
  .vec_o   (vec_o),
  .glb_i   (glb_q),
  .act_hi_i(act_hi)
);

// File: tb/sim_irq8_ctrl.sv
module sim_irq8_ctrl;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic [5:0] lg_req = '0;
  logic pa = 1'b1, pb = 1'b1;
  logic en_wr = 0, pri_wr = 0, xctl_wr = 0, ack = 0, reti = 0;
  logic [7:0] wdata = '0;
  logic [7:0] xctl, vec;
  logic irq;
  int nvec = 0, nbad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq8_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .src_req_i(lg_req),
    .ext_a_pin_i(pa), .ext_b_pin_i(pb),
    .en_wr_i(en_wr), .pri_wr_i(pri_wr), .xctl_wr_i(xctl_wr), .wdata_i(wdata),
    .xctl_o(xctl), .irq_o(irq), .vec_o(vec), .ack_i(ack), .reti_i(reti)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int which, input logic [7:0] d);
    @(negedge clk);
    wdata = d;
    en_wr = (which == 0); pri_wr = (which == 1); xctl_wr = (which == 2);
    @(negedge clk);
    en_wr = 0; pri_wr = 0; xctl_wr = 0;
  endtask

  task automatic pulse_ack;
    @(negedge clk); ack = 1; @(negedge clk); ack = 0;
  endtask

  task automatic pulse_reti;
    @(negedge clk); reti = 1; @(negedge clk); reti = 0;
  endtask

  // drive a request set; lines A/B in level mode request on a low pin
  task automatic drive(input logic [7:0] r);
    lg_req = r[5:0]; pa = ~r[6]; pb = ~r[7];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    wt(3); rst_ni = 1; wt(2);
    // R12 reset state
    chk("R12 irq after reset", {7'd0, irq}, 8'h00);
    chk("R12 xctl after reset", xctl, 8'h00);
    drive(8'hFF); wt(5);
    chk("R12 disabled after reset", {7'd0, irq}, 8'h00);

    // R1 R2 R3 pair sweep, level mode lines
    wr(0, 8'hBF);
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        for (int p = 0; p < 4; p++) begin
          logic [7:0] hi, rq;
          int w;
          hi = '0; rq = '0;
          rq[i] = 1; rq[j] = 1;
          if (p[0]) hi[i] = 1;
          if (p[1]) hi[j] = 1;
          if (hi[i] != hi[j]) w = hi[i] ? i : j;
          else w = (i < j) ? i : j;
          wr(1, {2'b00, hi[5:0]});
          wr(2, {hi[7], 3'b100, hi[6], 3'b100});
          drive(rq); wt(5);
          chk($sformatf("R1 R2 R3 irq i=%0d j=%0d p=%0d", i, j, p), {7'd0, irq}, 8'h01);
          chk($sformatf("R1 R2 R3 vec i=%0d j=%0d p=%0d", i, j, p), vec, 8'h03 + 8'(8 * w));
        end
      end
    end

    // R4 R5 per-source enable
    wr(1, 8'h00);
    for (int k = 0; k < 8; k++) begin
      logic [7:0] rq;
      rq = '0; rq[k] = 1;
      drive(rq);
      wr(0, (k < 6) ? (8'hBF & ~(8'h01 << k)) : 8'hBF);
      wr(2, (k == 6) ? 8'h40 : (k == 7) ? 8'h04 : 8'h44);
      wt(5);
      chk($sformatf("R4 R5 disabled src %0d", k), {7'd0, irq}, 8'h00);
    end
    drive(8'h3F); wr(2, 8'h00); wr(0, 8'h3F); wt(5);
    chk("R4 global off", {7'd0, irq}, 8'h00);
    drive(8'h00);

    // R6 R7 edge mode on line A
    wr(0, 8'h80); wr(2, 8'h05); pa = 1; wt(5);
    chk("R6 no edge no irq", {7'd0, irq}, 8'h00);
    pa = 0; wt(6);
    chk("R6 flag set", xctl, 8'h07);
    chk("R6 irq", {7'd0, irq}, 8'h01);
    chk("R6 vec", vec, 8'h33);
    pulse_ack;
    chk("R9 irq low after ack", {7'd0, irq}, 8'h00);
    chk("R7 flag cleared", xctl, 8'h05);
    pulse_reti; wt(5);
    chk("R6 held low no new request", {7'd0, irq}, 8'h00);
    pa = 1; wt(4); pa = 0; wt(6);
    chk("R6 second edge", {7'd0, irq}, 8'h01);
    wr(2, 8'h05); wt(4);
    chk("R7 sw clear flag", xctl, 8'h05);
    chk("R7 sw clear irq", {7'd0, irq}, 8'h00);

    // R8 level mode on line B
    pa = 1; wr(2, 8'h40); pb = 0; wt(6);
    chk("R8 level irq", {7'd0, irq}, 8'h01);
    chk("R8 level vec", vec, 8'h3B);
    chk("R8 flag not latched", xctl, 8'h40);
    pb = 1; wt(6);
    chk("R8 released", {7'd0, irq}, 8'h00);

    // R10 R11 nesting
    wr(2, 8'h00); wr(0, 8'hA1); wr(1, 8'h20);
    lg_req = 6'h01; wt(4);
    chk("R10 low vec", vec, 8'h03);
    pulse_ack;
    chk("R9 after low ack", {7'd0, irq}, 8'h00);
    wt(4);
    chk("R10 low blocks low", {7'd0, irq}, 8'h00);
    lg_req = 6'h21; wt(4);
    chk("R10 high preempts irq", {7'd0, irq}, 8'h01);
    chk("R10 high preempts vec", vec, 8'h2B);
    pulse_ack;
    wr(0, 8'hA3); wr(1, 8'h22); lg_req = 6'h23; wt(4);
    chk("R10 high blocks all", {7'd0, irq}, 8'h00);
    pulse_reti; wt(4);
    chk("R11 pop hi then hi eligible", vec, 8'h0B);
    chk("R11 pop hi irq", {7'd0, irq}, 8'h01);
    pulse_ack;
    lg_req = 6'h01;
    pulse_reti; wt(4);
    chk("R11 low level still active", {7'd0, irq}, 8'h00);
    pulse_reti; wt(4);
    chk("R11 low popped irq", {7'd0, irq}, 8'h01);
    chk("R11 low popped vec", vec, 8'h03);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule